// File: doc/BRIEF.md
# Dual MISR Bus Signature Unit

This block watches completed data transfers on a 64-bit processor bus and folds the data they carry into two 32-bit multiple-input signature registers. The upper word of the bus drives one register and the lower word drives the other, so every qualified beat advances both at once. Software can compare the resulting pair against a known-good value to detect corruption of the data path while the system runs.

Reads and writes are enabled separately. Each beat is masked byte lane by byte lane according to the strobes. A read that completes with an error contributes zeros instead of its data, and it raises a sticky error flag. A small register port lets software seed the signatures and a beat counter, clear all three at once, and push its own words into either signature. It can also read everything back. While the debug-halt input is high, bus beats are not accumulated, but software accesses still act.

Top module: `bus_signature_unit`

## Requirements
- R1: One signature step computes next = {cur[30:0], 0} XOR (cur[31] ? 32'hC000_0401 : 0) XOR d, which implements 1 + x^10 + x^30 + x^31 + x^32. For example, seed 32'h8000_0000 with d = 0 gives 32'hC000_0401.
- R2: One qualified beat steps the high signature with bus bits 63..32 and the low signature with bus bits 31..0, in the same clock edge.
- R3: Strobe bit i covers bus bits 8i+7..8i. When that strobe is low, the lane's bits enter the signature as zeros.
- R4: Control bit 2 (read enable) gates accumulation of reads, and control bit 1 (write enable) gates accumulation of writes. A beat of a disabled direction leaves both signatures and the counter unchanged.
- R5: A read beat that is accumulated and has xfer_err high enters the signatures as all-zero data and sets status bit 0. Status bit 0 is cleared only by writing 1 to it. Writing 0 to it has no effect, and a write beat with an error never sets it.
- R6: While control bit 5 (count enable) is set, the counter gains one for each accumulated bus beat and for each write to the low update register. A write to the high update register never changes the counter, and nothing advances the counter while bit 5 is clear.
- R7: Writing a word to the high update register (index 5) steps the high signature with that word. Writing a word to the low update register (index 6) steps the low signature with it. Both update registers read as 0.
- R8: Writing a control word with bit 0 set clears both signatures and the counter to 0. Bit 0 always reads back as 0, and the other control bits take the written value.
- R9: While dbg_halt is high, bus beats change neither the signatures, nor the counter, nor the error flag. Register writes still take effect.
- R10: Register indices are 0 control, 1 status, 2 high signature, 3 low signature, 4 counter, 5 high update, 6 low update. Reset clears control and status. Reset leaves the signatures and the counter unchanged, and a direct write to index 2, 3 or 4 loads the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control and status |
| dbg_halt | input | 1 | Suppresses bus-driven updates while high |
| xfer_done | input | 1 | A data beat completes this cycle |
| xfer_wr | input | 1 | 1 for a write beat, 0 for a read beat |
| xfer_err | input | 1 | The completing beat ended in error |
| xfer_strb | input | 8 | Active byte lanes of the beat |
| bus_rdata | input | 64 | Read data |
| bus_wdata | input | 64 | Write data |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |

## Verification
The bench builds the block with its default parameters: 32-bit signatures, eight 8-bit lanes and the taps 32'hC000_0401. These values let every lane be tested alone, first through a strobe of 0x0F and then through 0xA5. They also let the feedback path be checked against a constant worked out by hand when bit 31 of the seed is set. A scoreboard model follows the seeds, the beats, the update writes and the halt input, so it can check each register after each mixed sequence.

// File: rtl/bus_signature_unit.sv
module bus_signature_unit #(
  parameter int SIG_W = 32,
  parameter int LANES = 8,
  parameter logic [SIG_W-1:0] TAPS = 32'hC000_0401
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbg_halt,
  input  logic                 xfer_done,
  input  logic                 xfer_wr,
  input  logic                 xfer_err,
  input  logic [LANES-1:0]     xfer_strb,
  input  logic [2*SIG_W-1:0]   bus_rdata,
  input  logic [2*SIG_W-1:0]   bus_wdata,
  input  logic                 reg_we,
  input  logic [2:0]           reg_sel,
  input  logic [SIG_W-1:0]     reg_wdata,
  output logic [SIG_W-1:0]     reg_rdata
);
  localparam int BUS_W  = 2 * SIG_W;
  localparam int LANE_W = BUS_W / LANES;
  localparam logic [2:0] IX_CTRL = 3'd0, IX_STAT = 3'd1, IX_HI = 3'd2, IX_LO = 3'd3,
                         IX_CNT = 3'd4, IX_UHI = 3'd5, IX_ULO = 3'd6;

  logic cnt_en, rd_en, wr_en, terr;
  logic [SIG_W-1:0] sig_hi, sig_lo, cnt;
  logic [BUS_W-1:0] lane_mask, beat;

  function automatic logic [SIG_W-1:0] step(input logic [SIG_W-1:0] cur, input logic [SIG_W-1:0] d);
    return {cur[SIG_W-2:0], 1'b0} ^ ({SIG_W{cur[SIG_W-1]}} & TAPS) ^ d;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{xfer_strb[g]}};
  end

  wire rd_hit  = xfer_done & ~xfer_wr & rd_en & ~dbg_halt;
  wire wr_hit  = xfer_done &  xfer_wr & wr_en & ~dbg_halt;
  wire bus_hit = rd_hit | wr_hit;
  assign beat  = (xfer_wr ? bus_wdata : (xfer_err ? '0 : bus_rdata)) & lane_mask;

  wire wr_ctrl = reg_we && reg_sel == IX_CTRL;
  wire init_wr = wr_ctrl && reg_wdata[0];
  wire upd_hi  = reg_we && reg_sel == IX_UHI;
  wire upd_lo  = reg_we && reg_sel == IX_ULO;

  wire [SIG_W-1:0] hi_bus = bus_hit ? step(sig_hi, beat[BUS_W-1:SIG_W]) : sig_hi;
  wire [SIG_W-1:0] lo_bus = bus_hit ? step(sig_lo, beat[SIG_W-1:0]) : sig_lo;
  wire [SIG_W-1:0] hi_nxt = upd_hi ? step(hi_bus, reg_wdata) : hi_bus;
  wire [SIG_W-1:0] lo_nxt = upd_lo ? step(lo_bus, reg_wdata) : lo_bus;
  wire [1:0] cnt_inc = cnt_en ? {1'b0, bus_hit} + {1'b0, upd_lo} : 2'd0;

  always_ff @(posedge clk) begin
    if (init_wr) begin
      sig_hi <= '0;
      sig_lo <= '0;
      cnt    <= '0;
    end else begin
      sig_hi <= (reg_we && reg_sel == IX_HI)  ? reg_wdata : hi_nxt;
      sig_lo <= (reg_we && reg_sel == IX_LO)  ? reg_wdata : lo_nxt;
      cnt    <= (reg_we && reg_sel == IX_CNT) ? reg_wdata : cnt + SIG_W'(cnt_inc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cnt_en, rd_en, wr_en} <= '0;
      terr <= 1'b0;
    end else begin
      if (wr_ctrl) {cnt_en, rd_en, wr_en} <= {reg_wdata[5], reg_wdata[2], reg_wdata[1]};
      if (rd_hit && xfer_err) terr <= 1'b1;
      else if (reg_we && reg_sel == IX_STAT && reg_wdata[0]) terr <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      IX_CTRL: reg_rdata = SIG_W'({cnt_en, 2'b00, rd_en, wr_en, 1'b0});
      IX_STAT: reg_rdata = SIG_W'(terr);
      IX_HI:   reg_rdata = sig_hi;
      IX_LO:   reg_rdata = sig_lo;
      IX_CNT:  reg_rdata = cnt;
      default: reg_rdata = '0;
    endcase
  end

  // R8: INIT never reads back
  p_init_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == IX_CTRL |-> reg_rdata[0] == 1'b0);
  // R8: INIT clears signatures and counter
  p_init_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (sig_hi == '0 && sig_lo == '0 && cnt == '0));
  // R5: error flag is sticky
  p_terr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    terr && !(reg_we && reg_sel == IX_STAT && reg_wdata[0]) |=> terr);
  // R5: write errors are not logged
  p_wr_err_unlogged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !terr && !(xfer_done && !xfer_wr) |=> !terr);
  // R4: disabled reads leave the signatures alone
  p_rd_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !xfer_wr && !rd_en && !reg_we |=> ($stable(sig_hi) && $stable(sig_lo)));
  // R9: halt freezes bus-driven state
  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt && !reg_we |=> ($stable(sig_hi) && $stable(sig_lo) && $stable(cnt)));
  // R6: low update counts once when no beat competes
  p_cnt_low_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_lo && cnt_en && !bus_hit |=> cnt == $past(cnt) + SIG_W'(1));
  // R6: high update never counts
  p_cnt_high_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_hi && !bus_hit |=> $stable(cnt));
endmodule

// File: tb/bus_signature_unit_tb.sv
module bus_signature_unit_tb;
  logic clk = 0, rst_n = 0, dbg_halt = 0;
  logic xfer_done = 0, xfer_wr = 0, xfer_err = 0;
  logic [7:0] xfer_strb = 0;
  logic [63:0] bus_rdata = 0, bus_wdata = 0;
  logic reg_we = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;

  bus_signature_unit u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic chk = 0;

  logic [31:0] m_hi, m_lo, m_cnt;
  logic m_terr = 0, m_cnten = 0, m_rden = 0, m_wren = 0;

  function automatic logic [31:0] mstep(logic [31:0] c, logic [31:0] d);
    return {c[30:0], 1'b0} ^ (c[31] ? 32'hC000_0401 : 32'h0) ^ d;
  endfunction

  always @(negedge clk) if (chk) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
    end
  end

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    reg_we = 0; xfer_done = 0; chk = 0;
  endtask

  task automatic reg_write(input logic [2:0] ix, input logic [31:0] w);
    edge1(); idle();
    reg_we = 1; reg_sel = ix; reg_wdata = w;
    case (ix)
      3'd0: begin
        m_cnten = w[5]; m_rden = w[2]; m_wren = w[1];
        if (w[0]) begin m_hi = 0; m_lo = 0; m_cnt = 0; end
      end
      3'd1: if (w[0]) m_terr = 0;
      3'd2: m_hi = w;
      3'd3: m_lo = w;
      3'd4: m_cnt = w;
      3'd5: m_hi = mstep(m_hi, w);
      3'd6: begin m_lo = mstep(m_lo, w); if (m_cnten) m_cnt++; end
      default: ;
    endcase
  endtask

  task automatic bus_beat(input logic wr, input logic [7:0] strb, input logic [63:0] data, input logic err);
    logic [63:0] d;
    edge1(); idle();
    xfer_done = 1; xfer_wr = wr; xfer_strb = strb; xfer_err = err;
    if (wr) begin bus_wdata = data; bus_rdata = ~data; end
    else begin bus_rdata = data; bus_wdata = ~data; end
    if (!dbg_halt && ((wr && m_wren) || (!wr && m_rden))) begin
      d = (wr || !err) ? data : 64'h0;
      for (int i = 0; i < 8; i++) if (!strb[i]) d[i*8 +: 8] = 8'h00;
      m_hi = mstep(m_hi, d[63:32]);
      m_lo = mstep(m_lo, d[31:0]);
      if (m_cnten) m_cnt++;
      if (!wr && err) m_terr = 1;
    end
  endtask

  task automatic check_val(input logic [2:0] ix, input logic [31:0] e, input string t);
    edge1(); idle();
    reg_sel = ix; chk = 1;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic check(input logic [2:0] ix, input string t);
    logic [31:0] e;
    case (ix)
      3'd0: e = {26'b0, m_cnten, 2'b00, m_rden, m_wren, 1'b0};
      3'd1: e = {31'b0, m_terr};
      3'd2: e = m_hi;
      3'd3: e = m_lo;
      3'd4: e = m_cnt;
      default: e = 32'h0;
    endcase
    check_val(ix, e, t);
  endtask

  task automatic check_all(input string t);
    check(3'd2, {t, " hi"}); check(3'd3, {t, " lo"}); check(3'd4, {t, " cnt"});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check(3'd0, "R10 ctrl after reset");
    check(3'd1, "R10 status after reset");

    reg_write(3'd2, 32'h1234_5678);
    reg_write(3'd3, 32'h9ABC_DEF0);
    reg_write(3'd4, 32'd40);
    check_all("R10 seed");
    edge1(); idle(); rst_n = 0;
    edge1(); edge1(); rst_n = 1;
    check_all("R10 kept through reset");

    reg_write(3'd3, 32'h8000_0000);
    reg_write(3'd6, 32'h0);
    check_val(3'd3, 32'hC000_0401, "R1 feedback taps");
    reg_write(3'd3, 32'h0000_0001);
    reg_write(3'd6, 32'h0);
    check_val(3'd3, 32'h0000_0002, "R1 plain shift");

    reg_write(3'd0, 32'h27);
    check(3'd0, "R8 init reads zero");
    check_all("R8 init clears");
    bus_beat(1, 8'hFF, 64'hDEAD_BEEF_0BAD_F00D, 0);
    check_all("R2 full write beat");
    bus_beat(0, 8'hFF, 64'h0123_4567_89AB_CDEF, 0);
    check_all("R2 full read beat");
    bus_beat(1, 8'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    check_all("R3 strobe 0F");
    bus_beat(0, 8'hA5, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    check_all("R3 strobe A5");
    for (int k = 0; k < 6; k++)
      bus_beat(k[0], 8'(8'h11 << k) | 8'h80, {32'hC3A5_0000 ^ 32'(k), 32'h5A5A_1000 + 32'(k * 7)}, 0);
    check_all("R2 mixed burst");

    bus_beat(0, 8'hFF, 64'hFFFF_0000_FFFF_0000, 1);
    check_all("R5 errored read zero data");
    check(3'd1, "R5 error logged");
    reg_write(3'd1, 32'h0);
    check(3'd1, "R5 write 0 keeps flag");
    reg_write(3'd1, 32'h1);
    check(3'd1, "R5 w1c clears");
    bus_beat(1, 8'hFF, 64'h1111_2222_3333_4444, 1);
    check(3'd1, "R5 write error not logged");
    check_all("R5 errored write data kept");

    reg_write(3'd0, 32'h22);
    bus_beat(0, 8'hFF, 64'h7777_8888_9999_AAAA, 1);
    check_all("R4 read disabled");
    check(3'd1, "R4 disabled read error ignored");
    bus_beat(1, 8'hFF, 64'h7777_8888_9999_AAAA, 0);
    check_all("R4 write enabled");
    reg_write(3'd0, 32'h24);
    bus_beat(1, 8'hFF, 64'h5555_6666_7777_8888, 0);
    check_all("R4 write disabled");
    bus_beat(0, 8'hFF, 64'h5555_6666_7777_8888, 0);
    check_all("R4 read enabled");

    reg_write(3'd5, 32'hCAFE_0001);
    check_all("R7 high update no count");
    reg_write(3'd6, 32'hCAFE_0002);
    check_all("R7 low update counts R6");
    check(3'd5, "R7 high update reads 0");
    check(3'd6, "R7 low update reads 0");

    reg_write(3'd0, 32'h06);
    bus_beat(0, 8'hFF, 64'h0F0F_0F0F_F0F0_F0F0, 0);
    reg_write(3'd6, 32'h1357_9BDF);
    check_all("R6 count disabled");

    reg_write(3'd0, 32'h26);
    edge1(); idle(); dbg_halt = 1;
    bus_beat(0, 8'hFF, 64'hABCD_ABCD_ABCD_ABCD, 1);
    bus_beat(1, 8'hFF, 64'hABCD_ABCD_ABCD_ABCD, 0);
    check_all("R9 halt blocks beats");
    check(3'd1, "R9 halt no error log");
    reg_write(3'd6, 32'h2468_ACE0);
    reg_write(3'd5, 32'h0246_8ACE);
    check_all("R9 software update during halt");
    edge1(); idle(); dbg_halt = 0;
    bus_beat(1, 8'h3C, 64'h9999_9999_9999_9999, 0);
    check_all("R9 beats resume");

    edge1(); idle();
    edge1(); edge1();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule